// File: doc/BRIEF.md
# Packet-Boundary Admission Receive FIFO

This block buffers a receive stream that cannot be stalled. Each beat carries a data word, a byte-enable mask, an end-of-packet flag and a start-of-packet flag. The block has no ready signal. When the start beat of a packet arrives, the block checks an almost-full flag. That flag is raised whenever free space drops below a margin sized to one maximum-length packet. If the flag is low, every beat of that packet is stored. If it is high, every beat of that packet is thrown away. A packet is therefore never cut short, and the storage only ever holds whole packets.

The consumer reads with first-word-fall-through. The oldest stored word is presented whenever the empty flag is low, and a read strobe removes it. A counter reports how many packets have been thrown away.

Top module: `pkt_admit_rx_fifo`

## Requirements
- R1: After a synchronous active-low reset, `out_empty` is 1, `prog_full` is 0 and `drop_count` is 0.
- R2: An admitted packet is stored one entry per beat, in arrival order. Each entry holds the end flag, the 16-bit byte mask and the 128-bit data of its beat, and is returned unchanged on `out_last`, `out_keep` and `out_data`.
- R3: A beat with `in_sop` low that arrives while no packet is open is discarded.
- R4: `prog_full` is 1 exactly when the number of stored entries exceeds DEPTH minus MARGIN. With the defaults 1024 and 100, it is low at 924 entries and high at 925. It follows the stored count in the cycle after the clock edge that changes that count.
- R5: The decision is taken on the beat with `in_valid` and `in_sop` both high. If `prog_full` is low, every beat of that packet is stored. If it is high, no beat of that packet changes the storage. The next start beat is checked again.
- R6: The decision made on the start beat holds until the beat with `in_last` high, whatever `prog_full` does in the meantime.
- R7: `drop_count` increases by exactly one per discarded packet. The new value is visible after the clock edge of that packet's start beat.
- R8: While `out_empty` is low, the outputs show the oldest entry, and `rd_en` removes it at the clock edge. While `out_empty` is high, `rd_en` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input beat present |
| in_sop | input | 1 | Beat is the first beat of a packet |
| in_last | input | 1 | Beat is the last beat of a packet |
| in_keep | input | 16 | Byte enables of the beat |
| in_data | input | 128 | Data of the beat |
| rd_en | input | 1 | Remove the oldest entry |
| out_empty | output | 1 | No entry stored |
| out_last | output | 1 | End flag of the oldest entry |
| out_keep | output | 16 | Byte mask of the oldest entry |
| out_data | output | 128 | Data of the oldest entry |
| prog_full | output | 1 | Free space is below the margin |
| drop_count | output | 16 | Number of discarded packets, wrapping |

## Verification
A stored beat becomes visible one edge after it is presented. After that edge, `out_empty` falls and `prog_full` reflects the new count. A read takes effect at the same edge as its strobe, and `drop_count` changes at the edge of the dropped start beat.

The bench drives every input on the falling edge and compares outputs on the next falling edge. It therefore reads exactly one register stage after each stimulus edge. The head of the FIFO is compared just before each read strobe is applied. An expected-word queue is filled only with the beats the scenario declares admitted, and draining must empty that queue exactly.

// File: rtl/pkt_admit_pkg.sv
// Shared widths and the stored word layout for the admission FIFO.
// Assumes 16 byte lanes of 8 bits each.
package pkt_admit_pkg;
    localparam int KEEP_W = 16;
    localparam int DATA_W = KEEP_W * 8;
    localparam int WORD_W = 1 + KEEP_W + DATA_W;

    typedef struct packed {
        logic              last;
        logic [KEEP_W-1:0] keep;
        logic [DATA_W-1:0] data;
    } beat_t;
endpackage

// File: rtl/pkt_admit_store.sv
// Single-clock first-word-fall-through storage with an occupancy counter
// and an almost-full flag. Assumes the writer never pushes when full;
// the admission margin upstream guarantees that.
module pkt_admit_store #(
    parameter int DEPTH  = 1024,
    parameter int MARGIN = 100,
    parameter int WIDTH  = 145
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             rd_en,
    output logic [WIDTH-1:0] rdata,
    output logic             empty,
    output logic             almost_full
);
    localparam int AW     = $clog2(DEPTH);
    localparam int CW     = AW + 1;
    localparam int LIMIT  = DEPTH - MARGIN;

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr, rd_ptr;
    logic [CW-1:0]    count;
    logic             pop;

    assign pop         = rd_en && (count != '0);
    assign empty       = (count == '0);
    assign almost_full = (count > CW'(LIMIT));
    assign rdata       = mem[rd_ptr];

    // Store the incoming word at the write pointer.
    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= wdata;
    end

    // Advance pointers and track the number of stored entries.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (pop)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (count < CW'(DEPTH)));
    p_count_up_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !rd_en) |=> (count == $past(count) + 1'b1));
    p_empty_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && !push) |=> empty);
endmodule

// File: rtl/pkt_admit_ctrl.sv
// Per-packet admission control. It decides on the start beat from the
// almost-full flag and holds that decision until the last beat. It also
// counts discarded packets. Assumes the input stream cannot be stalled.
module pkt_admit_ctrl #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_sop,
    input  logic             in_last,
    input  logic             almost_full,
    output logic             wr_en,
    output logic [CNT_W-1:0] drop_cnt
);
    logic open_q;    // a packet is in progress
    logic admit_q;   // decision for the packet in progress
    logic start;

    assign start = in_valid && in_sop;
    assign wr_en = start ? !almost_full : (in_valid && open_q && admit_q);

    // Track the open packet and latch the decision taken on its start beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_q  <= 1'b0;
            admit_q <= 1'b0;
        end else if (start) begin
            open_q  <= !in_last;
            admit_q <= !almost_full;
        end else if (in_valid && open_q && in_last) begin
            open_q  <= 1'b0;
        end
    end

    // Count each packet that is rejected at its start beat.
    always_ff @(posedge clk) begin
        if (!rst_n)                    drop_cnt <= '0;
        else if (start && almost_full) drop_cnt <= drop_cnt + 1'b1;
    end

    p_drop_nowrite_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (start && almost_full) |-> !wr_en);
    p_drop_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (start && almost_full) |=> (drop_cnt == $past(drop_cnt) + 1'b1));
    p_hold_admit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_sop && open_q && admit_q) |-> wr_en);
    p_stray_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_sop && !open_q) |-> !wr_en);
endmodule

// File: rtl/pkt_admit_rx_fifo.sv
// Receive FIFO that stores only whole packets. A packet is admitted or
// discarded as a unit on its start beat. Assumes packets are at most
// MARGIN beats long, so an admitted packet always fits.
module pkt_admit_rx_fifo
    import pkt_admit_pkg::*;
#(
    parameter int DEPTH  = 1024,
    parameter int MARGIN = 100,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_sop,
    input  logic              in_last,
    input  logic [KEEP_W-1:0] in_keep,
    input  logic [DATA_W-1:0] in_data,
    input  logic              rd_en,
    output logic              out_empty,
    output logic              out_last,
    output logic [KEEP_W-1:0] out_keep,
    output logic [DATA_W-1:0] out_data,
    output logic              prog_full,
    output logic [CNT_W-1:0]  drop_count
);
    beat_t wr_word, rd_word;
    logic  wr_en;

    assign wr_word = '{last: in_last, keep: in_keep, data: in_data};
    assign out_last = rd_word.last;
    assign out_keep = rd_word.keep;
    assign out_data = rd_word.data;

    pkt_admit_ctrl #(.CNT_W(CNT_W)) i_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_sop     (in_sop),
        .in_last    (in_last),
        .almost_full(prog_full),
        .wr_en      (wr_en),
        .drop_cnt   (drop_count)
    );

    pkt_admit_store #(.DEPTH(DEPTH), .MARGIN(MARGIN), .WIDTH(WORD_W)) i_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (wr_en),
        .wdata      (wr_word),
        .rd_en      (rd_en),
        .rdata      (rd_word),
        .empty      (out_empty),
        .almost_full(prog_full)
    );

    p_pfull_nonempty_r4: assert property (@(posedge clk) disable iff (!rst_n)
        prog_full |-> !out_empty);
endmodule

// File: tb/test_pkt_admit_rx_fifo.sv
module test_pkt_admit_rx_fifo;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0, in_sop = 1'b0, in_last = 1'b0, rd_en = 1'b0;
    logic [15:0]  in_keep = '0;
    logic [127:0] in_data = '0;
    logic         out_empty, out_last, prog_full;
    logic [15:0]  out_keep, drop_count;
    logic [127:0] out_data;

    int n_tests = 0;
    int n_fail  = 0;
    logic [144:0] expq [$];

    always #2 clk = ~clk;

    pkt_admit_rx_fifo i_pkt_admit_rx_fifo (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop),
        .in_last(in_last), .in_keep(in_keep), .in_data(in_data), .rd_en(rd_en),
        .out_empty(out_empty), .out_last(out_last), .out_keep(out_keep),
        .out_data(out_data), .prog_full(prog_full), .drop_count(drop_count)
    );

    task automatic chk(input bit ok, input string tag, input logic [144:0] act,
                       input logic [144:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One beat: compare head before any read, then drive the beat.
    task automatic beat(input bit v, input bit sop, input bit last, input [15:0] keep,
                        input [127:0] data, input bit rd, input bit store);
        @(negedge clk);
        if (rd && expq.size() > 0) begin
            chk({out_last, out_keep, out_data} === expq[0], "R8 head before pop",
                {out_last, out_keep, out_data}, expq[0]);
            void'(expq.pop_front());
        end
        in_valid = v; in_sop = sop; in_last = last; in_keep = keep; in_data = data;
        rd_en = rd;
        if (v && store) expq.push_back({last, keep, data});
    endtask

    task automatic idle();
        beat(1'b0, 1'b0, 1'b0, '0, '0, 1'b0, 1'b0);
    endtask

    task automatic send_pkt(input int id, input int n, input bit admit, input int npops);
        for (int i = 0; i < n; i++)
            beat(1'b1, i == 0, i == n - 1, (i == n - 1) ? 16'h01ff : 16'hffff,
                 {id[31:0], 64'h0, i[31:0]}, (i >= 1) && (i <= npops), admit);
    endtask

    task automatic drain(input string tag);
        int got = 0;
        forever begin
            @(negedge clk);
            if (out_empty) begin rd_en = 1'b0; break; end
            if (expq.size() == 0) begin
                chk(1'b0, {tag, " extra entry"}, {out_last, out_keep, out_data}, '0);
                rd_en = 1'b1;
            end else begin
                chk({out_last, out_keep, out_data} === expq[0], tag,
                    {out_last, out_keep, out_data}, expq[0]);
                void'(expq.pop_front());
                rd_en = 1'b1;
            end
            got++;
        end
        chk(expq.size() == 0, {tag, " missing entries"}, expq.size(), 0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_empty === 1'b1, "R1 empty after reset", out_empty, 1);
        chk(prog_full === 1'b0, "R1 prog_full after reset", prog_full, 0);
        chk(drop_count === 16'd0, "R1 drop_count after reset", drop_count, 0);
    endtask

    task automatic t_basic();
        send_pkt(1, 3, 1'b1, 0);
        idle();
        chk(out_empty === 1'b0, "R2 not empty after admitted packet", out_empty, 0);
        drain("R2 packet content and order");
        idle();
        chk(out_empty === 1'b1, "R8 empty after drain", out_empty, 1);
    endtask

    task automatic t_stray_and_empty_read();
        beat(1'b1, 1'b0, 1'b0, 16'hffff, 128'hdead, 1'b0, 1'b0);
        beat(1'b1, 1'b0, 1'b1, 16'h0001, 128'hbeef, 1'b0, 1'b0);
        idle();
        chk(out_empty === 1'b1, "R3 stray beats discarded", out_empty, 1);
        beat(1'b0, 1'b0, 1'b0, '0, '0, 1'b1, 1'b0);   // read while empty
        idle();
        send_pkt(2, 2, 1'b1, 0);
        idle();
        drain("R8 read while empty has no effect");
    endtask

    task automatic t_fill_and_drop();
        for (int p = 0; p < 9; p++) send_pkt(10 + p, 94, 1'b1, 0);
        send_pkt(19, 78, 1'b1, 0);
        idle();
        chk(prog_full === 1'b0, "R4 prog_full low at 924", prog_full, 0);
        send_pkt(20, 1, 1'b1, 0);
        idle();
        chk(prog_full === 1'b1, "R4 prog_full high at 925", prog_full, 1);
        send_pkt(21, 5, 1'b0, 0);
        idle();
        chk(drop_count === 16'd1, "R7 one drop counted", drop_count, 1);
        chk(prog_full === 1'b1, "R5 dropped packet leaves storage unchanged", prog_full, 1);
        // Decision to drop held while pops clear prog_full mid-packet.
        send_pkt(22, 6, 1'b0, 2);
        idle();
        chk(prog_full === 1'b0, "R4 prog_full clears after pops (923)", prog_full, 0);
        chk(drop_count === 16'd2, "R6 R7 held drop counted once", drop_count, 2);
        // Admitted packet kept whole while prog_full rises mid-packet.
        send_pkt(23, 94, 1'b1, 0);
        idle();
        chk(prog_full === 1'b1, "R6 admitted packet completed (1017)", prog_full, 1);
        chk(drop_count === 16'd2, "R6 admitted packet not counted", drop_count, 2);
        send_pkt(24, 3, 1'b0, 0);
        idle();
        chk(drop_count === 16'd3, "R5 R7 next boundary rechecked, dropped", drop_count, 3);
        drain("R5 R6 stored content after fill");
        idle();
        chk(prog_full === 1'b0, "R4 prog_full low after drain", prog_full, 0);
        send_pkt(25, 4, 1'b1, 0);
        idle();
        drain("R5 admission resumes when room returns");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_basic();
        t_stray_and_empty_read();
        t_fill_and_drop();
        repeat (2) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule